// File: doc/BRIEF.md
# Byte Add/Subtract Unit with Status Flags

This block takes two operands and an incoming carry, adds them or subtracts the second from the first, and returns the result with four flags: carry, zero, negative and signed overflow. Subtraction uses the same ripple adder. The second operand is inverted bit by bit, and the incoming carry supplies the missing +1. A carry of 1 therefore means "no borrow", both as an input and as an output. This lets a wider operation be split over several bytes: the carry-out of one byte is fed back as the carry-in of the next, lowest byte first.

The signed-overflow flag does not come from a wider comparison. It is built from the sign bits of the two adder inputs (after any inversion) and the carry into the top bit, using a NOR/NAND gate network. Operations arrive on a valid/ready stream and leave one cycle later from an output register.

Back-pressure rules are as follows:
- An operation is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or its content is being consumed in the same cycle.
- While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `addsub_unit`

## Requirements
- R1: With `in_op` = 0 (add), the result is (A + B + carry-in) mod 2^W, and the carry-out is bit W of that sum.
- R2: With `in_op` = 1 (subtract), the result is (A + ~B + carry-in) mod 2^W. The carry-out is 1 exactly when A − B − (1 − carry-in) ≥ 0, that is, when no borrow occurred.
- R3: The overflow flag is 1 exactly when the two's-complement value of the true operation falls outside the range −2^(W−1) to 2^(W−1)−1. The true operation is sA + sB + cin for add and sA − sB − (1 − cin) for subtract. Adding a positive and a negative operand never sets the flag.
- R4: The overflow flag always equals the carry into the top bit XOR the carry out of the top bit.
- R5: The zero flag is 1 exactly when all W result bits are 0.
- R6: The negative flag equals the top bit of the result.
- R7: An operation accepted on a clock edge appears with `out_valid` high after that edge. `in_ready` is low only while `out_valid` is high and `out_ready` is low. The output empties after a consumed beat when no new operation is accepted.
- R8: While `out_valid` is high and `out_ready` is low, the result and all flags stay unchanged, and an offered input is not taken.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation |
| in_op | input | 1 | 0 = add with carry, 1 = subtract with inverted borrow |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| in_carry | input | 1 | Carry-in (for subtract: 1 = no borrow) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | W | Result |
| out_carry | output | 1 | Carry-out (for subtract: 1 = no borrow) |
| out_zero | output | 1 | Result is zero |
| out_neg | output | 1 | Top bit of the result |
| out_ovf | output | 1 | Signed overflow |

## Verification
The first operand sweeps every value for both operations and both carry-in values. The second operand covers every value, offset by the low bits of the first, so each pairing of sign bits and carry into the top bit occurs many times. This separates true signed overflow from an unsigned carry and from a mixed-sign sum. Fixed vectors pin down both overflow directions, with and without borrow. A stall sequence shows that held output is preserved and that the offered input is not taken until the consumer releases. Zero results from wrap-around check the zero flag together with the carry.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/addsub_opnd.sv
module addsub_opnd #(
  parameter int W = 8
) (
  input  logic         sub_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_eff_o
);
  // Subtraction adds the ones complement of the second operand.
  always_comb b_eff_o = b_i ^ {W{sub_i}};
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);
  logic [W:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] | b_i[i]));
  end

  assign c_msb_o = c[W-1];
  assign cout_o  = c[W];
endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic c_msb_i,
  input  logic c_out_i,
  output logic ovf_o
);
  logic both_clear, not_both_set, pos_term, neg_term;

  // Gate form: two positives with a carry into the top bit, or two
  // negatives without one.
  always_comb begin
    both_clear   = ~(a_msb_i | b_msb_i);
    not_both_set = ~(a_msb_i & b_msb_i);
    pos_term     = both_clear & c_msb_i;
    neg_term     = ~(not_both_set | c_msb_i);
    ovf_o        = ~(~(pos_term | neg_term));
  end

  // R4: gate form agrees with the top-bit carry difference
  always_comb begin
    assert_ovf_xor_R4: assert (ovf_o == (c_msb_i ^ c_out_i))
      else $error("overflow gate form disagrees with carry xor");
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_carry,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_carry,
  output logic         out_zero,
  output logic         out_neg,
  output logic         out_ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff, sum;
  logic         c_msb, c_out, ovf;
  logic         take;
  flags_t       flags_d, flags_q;
  logic [W-1:0] res_q;
  logic         vld_q;

  addsub_opnd #(.W(W)) u_opnd (
    .sub_i   (op_e'(in_op) == OP_SUB),
    .b_i     (in_b),
    .b_eff_o (b_eff)
  );

  addsub_ripple #(.W(W)) u_add (
    .a_i     (in_a),
    .b_i     (b_eff),
    .cin_i   (in_carry),
    .sum_o   (sum),
    .c_msb_o (c_msb),
    .cout_o  (c_out)
  );

  addsub_ovf u_ovf (
    .a_msb_i (in_a[MSB]),
    .b_msb_i (b_eff[MSB]),
    .c_msb_i (c_msb),
    .c_out_i (c_out),
    .ovf_o   (ovf)
  );

  always_comb begin
    flags_d.carry = c_out;
    flags_d.zero  = ~|sum;
    flags_d.neg   = sum[MSB];
    flags_d.ovf   = ovf;
  end

  assign in_ready = ~vld_q | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (take) begin
        vld_q   <= 1'b1;
        res_q   <= sum;
        flags_q <= flags_d;
      end else if (out_ready) begin
        vld_q   <= 1'b0;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_carry  = flags_q.carry;
  assign out_zero   = flags_q.zero;
  assign out_neg    = flags_q.neg;
  assign out_ovf    = flags_q.ovf;

  // R5: zero flag matches the held result
  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));

  // R6: negative flag matches the held top bit
  assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_neg == out_result[MSB]));

  // R7: an accepted operation is presented next cycle
  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7: a stall only happens with a full, unconsumed output
  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  // R8: held output stays put under back-pressure
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_carry) && $stable(out_ovf) && $stable(out_zero)));
endmodule

// File: tb/tb_addsub_unit.sv
module tb_addsub_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, in_op, in_carry;
  logic [W-1:0] in_a, in_b;
  logic         out_valid, out_ready;
  logic [W-1:0] out_result;
  logic         out_carry, out_zero, out_neg, out_ovf;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic done = 1'b0;

  logic       pend = 1'b0;
  logic       e_op;
  int         e_res;
  logic       e_c, e_z, e_n, e_v;

  always #5 clk = ~clk;

  addsub_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_carry(out_carry), .out_zero(out_zero), .out_neg(out_neg),
    .out_ovf(out_ovf)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung at cycle %0d (expected end)", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Expected values computed arithmetically from R1, R2, R3, R5 and R6.
  task automatic model(input logic op, input int a, input int b, input logic c);
    int full, tru;
    if (op == 1'b0) begin
      full = a + b + int'(c);
      tru  = sx(a) + sx(b) + int'(c);
      e_c  = full[8];
    end else begin
      full = a + (255 - b) + int'(c);
      tru  = sx(a) - sx(b) - (1 - int'(c));
      e_c  = ((a - b - (1 - int'(c))) >= 0);
    end
    e_op  = op;
    e_res = full & 255;
    e_z   = (e_res == 0);
    e_n   = e_res[7];
    e_v   = (tru > 127) || (tru < -128);
  endtask

  task automatic check_out();
    logic bad = 1'b0;
    n_tests++;
    if (out_valid !== 1'b1) begin
      bad = 1'b1; $display("FAIL R7 out_valid: got %b exp 1", out_valid);
    end
    if (int'(out_result) != e_res) begin
      bad = 1'b1;
      $display("FAIL %s result: got %02h exp %02h", e_op ? "R2" : "R1", out_result, e_res[7:0]);
    end
    if (out_carry !== e_c) begin
      bad = 1'b1;
      $display("FAIL %s carry: got %b exp %b", e_op ? "R2" : "R1", out_carry, e_c);
    end
    if (out_ovf !== e_v) begin
      bad = 1'b1; $display("FAIL R3 overflow: got %b exp %b", out_ovf, e_v);
    end
    if (out_zero !== e_z) begin
      bad = 1'b1; $display("FAIL R5 zero: got %b exp %b", out_zero, e_z);
    end
    if (out_neg !== e_n) begin
      bad = 1'b1; $display("FAIL R6 negative: got %b exp %b", out_neg, e_n);
    end
    if (bad) n_fail++;
  endtask

  task automatic send(input logic op, input int a, input int b, input logic c);
    @(negedge clk);
    if (pend) check_out();
    model(op, a, b, c);
    in_valid = 1'b1; in_op = op; in_a = a[7:0]; in_b = b[7:0]; in_carry = c;
    pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check_out();
    pend = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic expect_bit(input string tag, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h exp %02h", tag, got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 1'b0; in_a = '0; in_b = '0;
    in_carry = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    expect_bit("R9 out_valid after reset", out_valid, 1'b0);
    expect_bit("R9 in_ready after reset", in_ready, 1'b1);
    rst_n = 1'b1;

    // R3/R4 fixed vectors: both overflow directions, with and without borrow
    send(1'b0, 'h50, 'h50, 1'b0);  // A0, V=1, C=0
    send(1'b0, 'hD0, 'h90, 1'b0);  // 60, V=1, C=1
    send(1'b0, 'h50, 'hD0, 1'b0);  // 20, C=1, V=0 (mixed signs)
    send(1'b1, 'hD0, 'h70, 1'b1);  // 60, V=1, no borrow
    send(1'b1, 'h50, 'hB0, 1'b1);  // A0, V=1, borrow
    send(1'b0, 'hFF, 'h01, 1'b0);  // R5 wrap to zero
    send(1'b1, 'h33, 'h33, 1'b1);  // R5 zero, R2 no borrow
    send(1'b1, 'h00, 'h00, 1'b0);  // R2 borrow in gives FF
    flush();

    // Near-exhaustive sweep: every a, every b across the sweep, both ops and carries
    for (int op = 0; op < 2; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++)
          for (int j = 0; j < 64; j++)
            send(op[0], a, j * 4 + (a & 3), c[0]);
    flush();

    // R7/R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 1'b0; in_a = 8'h12; in_b = 8'h34; in_carry = 1'b0;
    @(posedge clk);
    @(negedge clk);
    expect_bit("R7 valid after accept", out_valid, 1'b1);
    expect_bit("R7 in_ready low when stalled", in_ready, 1'b0);
    expect_byte("R7 first result", out_result, 8'h46);
    in_a = 8'hFF; in_b = 8'h01;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      expect_byte("R8 held result", out_result, 8'h46);
      expect_bit("R8 held zero flag", out_zero, 1'b0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_byte("R8 offered input taken after release", out_result, 8'h00);
    expect_bit("R8 zero of released input", out_zero, 1'b1);
    expect_bit("R1 carry of released input", out_carry, 1'b1);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    expect_bit("R7 output drains", out_valid, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule